// File: doc/BRIEF.md
# Grouped Interrupt Line Merger

This block gathers a wide vector of level-sensitive peripheral interrupt lines into a short vector of parent requests, one request per group of eight lines. For every group it keeps eight enable bits. A group's parent request is high while at least one of its lines is both high and enabled. Beside each request the block gives a 3-bit index, which names the lowest-numbered line that is both high and enabled. A handler can then service that line without scanning the status word.

Software reaches the block through a plain word-addressed port. Groups are packed four to a 32-bit register bank, and each group uses one byte lane. Within a bank there is a word that sets enables, a word that clears enables and a word that shows the raw line levels. Because enables change only through set and clear words, no read-modify-write sequence is needed, and two handlers acting on different lines cannot lose each other's updates. The number of groups is a parameter. A last bank that is only partly filled reads as zero in its unused lanes.

Top module: `irq_group_merger`

## Requirements
- R1: After reset every enable bit is 0, every parent request is low, and enable readback returns 0 in every bank.
- R2: A write to bank offset 0x0 turns on each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to bank offset 0x4 turns off each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: Group n is in bank n/4 (integer division), at bank base address 16*(n/4), and uses bits [(n mod 4)*8+7 : (n mod 4)*8] of that bank's words. Line k of the group is bit (n mod 4)*8+k, which is source line n*8+k.
- R5: Parent request n is high exactly when some line of group n is high and has its enable bit set.
- R6: A read of bank offset 0xC returns the raw levels of the bank's source lines, whatever the enables are.
- R7: While parent request n is high, index n gives the lowest line number k (0..7) of group n that is high and enabled. While the request is low, the index is 0.
- R8: Reads of offsets 0x4 and 0x8, of addresses that are not word aligned, of banks past the last one, and of byte lanes with no group behind them all return 0. Writes to offset 0x8 or to a bank past the last one change no enable bit.
- R9: A read of bank offset 0x0 returns the current enable bits of the bank's groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | NUM_GROUPS*8 | Level interrupt lines; line n*8+k is line k of group n |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, applied at the clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| grpIrq | output | NUM_GROUPS | Parent request per group |
| grpIdx | output | NUM_GROUPS*3 | Lowest active enabled line per group; group n in bits [n*3+2:n*3] |

## Verification
The hardest case to reach is a partly filled last bank. Here a write carries ones in lanes that have no group behind them, and the enables of real groups must take the ones meant for them and ignore the rest. The bench uses six groups, so the second bank has two empty lanes and the address space holds two banks that do not exist. It writes all-ones to set and clear words at every bank and at the hole at 0x8, and it compares readback against a behavioural model. It also shows that the index tracks the lowest line: it keeps clearing the lowest enable bit while all lines are high, and it then drives a changing pseudo-random line pattern. Throughout, requests, indices and read data are compared with the model on every cycle.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  localparam int LANE_W = 8;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic wrSet;
    logic wrClr;
    logic rdEn;
    logic rdStat;
  } merge_strobe_t;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [LANE_W-1:0] vec);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 6,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output merge_strobe_t     strobes,
  output logic [BANK_W-1:0] bankIdx
);

  localparam int FIELD_W = ADDR_W - 4;

  logic [FIELD_W-1:0] bankField;
  logic [3:0]         offset;
  logic               bankOk;

  assign bankField = busAddr[ADDR_W-1:4];
  assign offset    = busAddr[3:0];
  assign bankOk    = (32'(bankField) < NUM_BANKS);
  assign bankIdx   = BANK_W'(bankField);

  always_comb begin
    strobes = '0;
    if (bankOk) begin
      unique case (offset)
        4'h0: begin
          strobes.wrSet = busWrEn;
          strobes.rdEn  = 1'b1;
        end
        4'h4: strobes.wrClr = busWrEn;
        4'hC: begin
          strobes.rdEn   = 1'b1;
          strobes.rdStat = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irq_merge_datapath.sv
module irq_merge_datapath
  import irq_merge_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  merge_strobe_t                strobes,
  input  logic [BANK_W-1:0]            bankIdx,
  input  logic [31:0]                  busWrData,
  input  logic [NUM_GROUPS*LANE_W-1:0] srcLines,
  output logic [31:0]                  busRdData,
  output logic [NUM_GROUPS-1:0]        grpIrq,
  output logic [NUM_GROUPS*IDX_W-1:0]  grpIdx
);

  logic [LANE_W-1:0] enBits [NUM_GROUPS];
  logic [31:0]       enWord [NUM_BANKS];
  logic [31:0]       statWord [NUM_BANKS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    localparam int LANE_LO = (g % 4) * LANE_W;
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(g / 4);

    logic [LANE_W-1:0] live;
    logic              hit;

    assign hit = (bankIdx == MY_BANK);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enBits[g] <= '0;
      end else if (strobes.wrSet && hit) begin
        enBits[g] <= enBits[g] | busWrData[LANE_LO +: LANE_W];
      end else if (strobes.wrClr && hit) begin
        enBits[g] <= enBits[g] & ~busWrData[LANE_LO +: LANE_W];
      end
    end

    assign live      = srcLines[g*LANE_W +: LANE_W] & enBits[g];
    assign grpIrq[g] = |live;
    assign grpIdx[g*IDX_W +: IDX_W] = lowestSet(live);
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      enWord[b]   = '0;
      statWord[b] = '0;
    end
    for (int g = 0; g < NUM_GROUPS; g++) begin
      enWord[g/4][(g%4)*LANE_W +: LANE_W]   = enBits[g];
      statWord[g/4][(g%4)*LANE_W +: LANE_W] = srcLines[g*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    busRdData = '0;
    if (strobes.rdEn) begin
      busRdData = strobes.rdStat ? statWord[bankIdx] : enWord[bankIdx];
    end
  end

endmodule

// File: rtl/irq_group_merger.sv
module irq_group_merger
  import irq_merge_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int ADDR_W     = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_GROUPS*8-1:0]  srcLines,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [31:0]              busWrData,
  output logic [31:0]              busRdData,
  output logic [NUM_GROUPS-1:0]    grpIrq,
  output logic [NUM_GROUPS*3-1:0]  grpIdx
);

  localparam int NUM_BANKS = (NUM_GROUPS + 3) / 4;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  merge_strobe_t     strobes;
  logic [BANK_W-1:0] bankIdx;

  irq_merge_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobes (strobes),
    .bankIdx (bankIdx)
  );

  irq_merge_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .bankIdx   (bankIdx),
    .busWrData (busWrData),
    .srcLines  (srcLines),
    .busRdData (busRdData),
    .grpIrq    (grpIrq),
    .grpIdx    (grpIdx)
  );

endmodule

// File: rtl/irq_group_merger_checker.sv
module irq_group_merger_checker #(
  parameter int NUM_GROUPS = 6,
  parameter int ADDR_W     = 6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_GROUPS*8-1:0] srcLines,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWrEn,
  input logic [31:0]             busWrData,
  input logic [31:0]             busRdData,
  input logic [NUM_GROUPS-1:0]   grpIrq,
  input logic [NUM_GROUPS*3-1:0] grpIdx
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (grpIrq == '0));

  p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[3:0] == 4'h8) |-> (busRdData == 32'h0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'((g / 4) * 16 + 4);
    localparam int LANE_LO = (g % 4) * 8;

    p_request_needs_line_r5: assert property (@(posedge clk) disable iff (!rstN)
      grpIrq[g] |-> (|srcLines[g*8 +: 8]));

    p_index_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
      !grpIrq[g] |-> (grpIdx[g*3 +: 3] == 3'd0));

    p_index_points_high_r7: assert property (@(posedge clk) disable iff (!rstN)
      grpIrq[g] |-> srcLines[g*8 + 32'(grpIdx[g*3 +: 3])]);

    p_full_clear_silences_r3: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == CLR_ADDR && busWrData[LANE_LO +: 8] == 8'hFF)
        |=> !grpIrq[g]);
  end

endmodule

bind irq_group_merger irq_group_merger_checker #(
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srcLines  (srcLines),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .grpIrq    (grpIrq),
  .grpIdx    (grpIdx)
);

// File: tb/irq_group_merger_test.sv
module irq_group_merger_test;

  localparam int NG = 6;
  localparam int AW = 6;
  localparam int NB = (NG + 3) / 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NG*8-1:0]   srcLines;
  logic [AW-1:0]     busAddr;
  logic              busWrEn;
  logic [31:0]       busWrData;
  logic [31:0]       busRdData;
  logic [NG-1:0]     grpIrq;
  logic [NG*3-1:0]   grpIdx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] mEn [NG];

  always #2.5 clk = ~clk;

  irq_group_merger #(.NUM_GROUPS(NG), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .grpIrq(grpIrq), .grpIdx(grpIdx)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: enable state updated at each clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < NG; g++) mEn[g] = 8'h00;
    end else if (busWrEn) begin
      int bank, off;
      bank = int'(busAddr) / 16;
      off  = int'(busAddr) % 16;
      for (int g = 0; g < NG; g++) begin
        if (g / 4 == bank) begin
          if (off == 0) mEn[g] = mEn[g] | busWrData[(g%4)*8 +: 8];
          else if (off == 4) mEn[g] = mEn[g] & ~busWrData[(g%4)*8 +: 8];
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [AW-1:0] a);
    int bank, off;
    logic [31:0] w;
    bank = int'(a) / 16;
    off  = int'(a) % 16;
    w = '0;
    for (int g = 0; g < NG; g++) begin
      if (g / 4 == bank) begin
        if (off == 0)  w[(g%4)*8 +: 8] = mEn[g];
        if (off == 12) w[(g%4)*8 +: 8] = srcLines[g*8 +: 8];
      end
    end
    return w;
  endfunction

  // Per-cycle comparison in the middle of the cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int g = 0; g < NG; g++) begin
        logic expIrq;
        logic [2:0] expIdx;
        expIrq = 1'b0;
        expIdx = 3'd0;
        for (int k = 7; k >= 0; k--) begin
          if (srcLines[g*8+k] && mEn[g][k]) begin
            expIrq = 1'b1;
            expIdx = 3'(k);
          end
        end
        check(grpIrq[g] == expIrq, $sformatf("R5 request group %0d", g), 32'(grpIrq[g]), 32'(expIrq));
        check(grpIdx[g*3 +: 3] == expIdx, $sformatf("R7 index group %0d", g), 32'(grpIdx[g*3 +: 3]), 32'(expIdx));
      end
      check(busRdData == expRead(busAddr), $sformatf("R9/R6/R8 read addr %h", busAddr), busRdData, expRead(busAddr));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rdExpect(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    @(negedge clk);
    check(busRdData == exp, tag, busRdData, exp);
    tick();
  endtask

  task automatic irqExpect(input logic [NG-1:0] exp, input string tag);
    @(negedge clk);
    check(grpIrq == exp, tag, 32'(grpIrq), 32'(exp));
    tick();
  endtask

  task automatic idxExpect(input int g, input logic [2:0] exp, input string tag);
    @(negedge clk);
    check(grpIdx[g*3 +: 3] == exp, tag, 32'(grpIdx[g*3 +: 3]), 32'(exp));
    tick();
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [47:0] lfsr;
    rstN = 1'b0; srcLines = '0; busAddr = '0; busWrEn = 1'b0; busWrData = '0;
    repeat (3) tick();
    rstN = 1'b1;

    // R1: reset state
    irqExpect('0, "R1 requests low after reset");
    rdExpect(6'h00, 32'h0, "R1 bank0 enables zero");
    rdExpect(6'h10, 32'h0, "R1 bank1 enables zero");

    // R6: raw status independent of enables
    srcLines = '1;
    rdExpect(6'h0C, 32'hFFFF_FFFF, "R6 bank0 raw status");
    rdExpect(6'h1C, 32'h0000_FFFF, "R6 bank1 raw status, empty lanes zero");
    irqExpect('0, "R5 no request with enables off");

    // R2/R4: set by lane
    wr(6'h00, 32'h0000_FF01);
    rdExpect(6'h00, 32'h0000_FF01, "R2 set readback");
    irqExpect(6'b000011, "R4 groups 0 and 1 request");
    wr(6'h00, 32'h0000_0002);
    rdExpect(6'h00, 32'h0000_FF03, "R2 zero bits keep value");

    // R3/R7: clear lowest, index moves up
    idxExpect(0, 3'd0, "R7 index 0");
    wr(6'h04, 32'h0000_0001);
    rdExpect(6'h00, 32'h0000_FF02, "R3 clear readback");
    idxExpect(0, 3'd1, "R7 index after clear");
    for (int k = 0; k < 7; k++) begin
      wr(6'h04, 32'(1) << (8 + k));
      idxExpect(1, 3'(k + 1), "R7 index walks up");
    end

    // R4/R8: second bank partly filled
    wr(6'h10, 32'hFFFF_FFFF);
    rdExpect(6'h10, 32'h0000_FFFF, "R8 empty lanes read zero");
    irqExpect(6'b110011, "R4 bank1 groups 4 and 5");

    // R8: hole, misaligned, and missing banks ignored
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h30, 32'hFFFF_FFFF);
    wr(6'h05, 32'hFFFF_FFFF);
    rdExpect(6'h00, 32'h0000_8002, "R8 bank0 unchanged by stray writes");
    rdExpect(6'h08, 32'h0, "R8 hole reads zero");
    rdExpect(6'h04, 32'h0, "R8 clear word reads zero");
    rdExpect(6'h2C, 32'h0, "R8 missing bank reads zero");
    rdExpect(6'h01, 32'h0, "R8 misaligned reads zero");

    // R9: enable all, then random line patterns
    wr(6'h00, 32'hFFFF_FFFF);
    rdExpect(6'h00, 32'hFFFF_FFFF, "R9 full readback");
    lfsr = 48'h1234_5678_9ABC;
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      srcLines = lfsr & {lfsr[23:0], lfsr[47:24]};
      busAddr = AW'((i % 4) * 4 + ((i / 4) % 2) * 16);
      tick();
    end

    // R3: clear everything
    srcLines = '1;
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    irqExpect('0, "R3 all cleared");
    rdExpect(6'h10, 32'h0, "R3 bank1 cleared");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule